// File: doc/BRIEF.md
# PCI Bridge Data Parity Error Responder

This block handles data parity errors for a bridge that joins two PCI segments: a primary side and a secondary side. On each side it watches the data phases, which are the clocks where both IRDY# and TRDY# are low. On the following clock it compares the PAR line against the even parity of AD and C/BE# captured in that data phase. From that result and the response enables it decides four things: whether to pull the PERR# line of the side that started the transfer, whether to set that side's sticky detected-error status bit, whether the far side's master logic must send the write on with deliberately corrupted parity, and whether a delayed write's stored completion may be handed back or must stay queued.

Errors that the far (target) bus reports for a transfer the initiating bus saw as clean are presented as a pass-back flag in the data phase. Such an error makes the block drive PERR# on the initiating side, and only when both response enables are set. Every response appears two clocks after the data phase and comes from a register.

Top module: `pci_parity_responder`

## Requirements
- R1: On each side a data phase is a clock with IRDY# and TRDY# both low. In the next clock, PAR is compared with the XOR of all AD and C/BE# bits of that data phase, so AD, C/BE# and PAR together must carry an even number of ones. A mismatch sets the side's status bit (bit 0 primary, bit 1 secondary) so that it reads 1 in the second clock after the data phase.
- R2: Status bits stay set until a clock with `stat_clr_wr` high, which clears each bit whose `stat_clr_mask` bit is 1 (bit 0 primary, bit 1 secondary). Bits whose mask bit is 0 keep their value. A new error in the same clock wins over the clear.
- R3: A detected error on a data phase flagged `rx_write` (the bridge is the target of a write on that side) drives that side's PERR# low with its output enable high during the second clock after the data phase. This happens only if that side's own enable is 1: `pri_perr_en` for primary, `sec_perr_en` for secondary. The other side's PERR# stays undriven.
- R4: After its last low clock, PERR# is driven high for exactly one clock with its enable still on, then released. Errors on consecutive data phases keep PERR# low over consecutive clocks.
- R5: A pass-back flag on a data phase drives PERR# low on that side two clocks later, and only when `pri_perr_en` and `sec_perr_en` are both 1. Pass-back alone sets no status bit and holds no delayed completion.
- R6: A detected error on a posted (`posted`=1) received write raises the far side's forward-bad-parity output for one clock, two clocks after the data phase. The near side's output stays low. No such pulse appears without an error, for non-posted writes, or for non-write phases.
- R7: A received non-posted write with `dw_stat_rdy`=1 gives a one-clock pulse two clocks after the data phase: `dw_release` when the parity matched, `dw_hold` when it did not. The two are never high together. PERR# still follows R3.
- R8: While reset is held and after it, both PERR# enables are 0, PERR# is 1, the status bits are 0 and all pulse outputs are 0.
- R9: A clock with only one of IRDY#/TRDY# low, or neither, is not checked. It sets no status and gives no PERR#, forward or release/hold pulse, whatever PAR is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_perr_en | input | 1 | Primary parity-error response enable |
| sec_perr_en | input | 1 | Secondary parity-error response enable |
| p_ad | input | DATA_W | Primary AD bus |
| p_cbe_n | input | BE_W | Primary C/BE# lines |
| p_par | input | 1 | Primary PAR, valid the clock after a data phase |
| p_irdy_n | input | 1 | Primary IRDY# |
| p_trdy_n | input | 1 | Primary TRDY# |
| p_rx_write | input | 1 | Bridge is target of a write on primary this phase |
| p_posted | input | 1 | Primary write is posted |
| p_dw_stat_rdy | input | 1 | Delayed-write completion queued for this primary write |
| p_passback | input | 1 | Far bus reported a parity error for this primary phase |
| s_ad | input | DATA_W | Secondary AD bus |
| s_cbe_n | input | BE_W | Secondary C/BE# lines |
| s_par | input | 1 | Secondary PAR |
| s_irdy_n | input | 1 | Secondary IRDY# |
| s_trdy_n | input | 1 | Secondary TRDY# |
| s_rx_write | input | 1 | Bridge is target of a write on secondary |
| s_posted | input | 1 | Secondary write is posted |
| s_dw_stat_rdy | input | 1 | Delayed-write completion queued for this secondary write |
| s_passback | input | 1 | Far bus reported a parity error for this secondary phase |
| stat_clr_wr | input | 1 | Write-one-to-clear strobe for status |
| stat_clr_mask | input | 2 | Bits to clear (0 primary, 1 secondary) |
| par_err_stat | output | 2 | Sticky detected-parity-error bits |
| p_perr_n | output | 1 | Primary PERR# value |
| p_perr_oe | output | 1 | Primary PERR# output enable |
| s_perr_n | output | 1 | Secondary PERR# value |
| s_perr_oe | output | 1 | Secondary PERR# output enable |
| p_fwd_bad_par | output | 1 | Primary master must drive inverted parity |
| s_fwd_bad_par | output | 1 | Secondary master must drive inverted parity |
| p_dw_release | output | 1 | Return primary delayed-write completion |
| p_dw_hold | output | 1 | Keep primary delayed-write entry queued |
| s_dw_release | output | 1 | Return secondary delayed-write completion |
| s_dw_hold | output | 1 | Keep secondary delayed-write entry queued |

## Verification
The bench builds the block with its default 32-bit AD and 4-bit C/BE#. It sweeps every combination of side, parity good or bad, handshake pattern, received-write, posted, completion-ready, pass-back and the four enable settings, with the bus data changing between runs. Because of that sweep, every way the enables, direction and write type combine into PERR#, forwarding and hold/release decisions is reached and checked against values worked out arithmetically. Directed sequences add back-to-back errors and selective clearing of the sticky bits.

// File: rtl/pci_par_pkg.sv
// Shared definitions for the bridge parity responder.
// Assumes exactly two bus sides, indexed primary then secondary.
package pci_par_pkg;

    localparam int NSIDE    = 2;
    localparam int SIDE_PRI = 0;
    localparam int SIDE_SEC = 1;

    // Facts captured at the end of a data phase, used one clock later with PAR.
    typedef struct packed {
        logic vld;      // a data phase was seen
        logic exp_par;  // even parity over AD and C/BE#
        logic rx;       // bridge was target of a write
        logic posted;   // that write was posted
        logic dw;       // delayed write with a completion waiting
        logic pb;       // far bus reported an error for this phase
    } stage_t;

endpackage

// File: rtl/pci_par_side_pipe.sv
// Per-side parity pipeline. Clock k: capture parity of AD/C/BE# on a data
// phase. Clock k+1: compare with PAR and register all responses, which are
// seen in clock k+2. Assumes PAR for clock k arrives in clock k+1.
module pci_par_side_pipe
    import pci_par_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad,
    input  logic [BE_W-1:0]   cbe_n,
    input  logic              par,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              rx_write,
    input  logic              posted,
    input  logic              dw_stat_rdy,
    input  logic              passback,
    input  logic              own_en,
    input  logic              both_en,
    output logic              det_err,
    output logic              perr_req,
    output logic              fwd_req,
    output logic              dw_release,
    output logic              dw_hold
);

    stage_t s1_q;
    logic   dphase;
    logic   mismatch;

    assign dphase = !irdy_n && !trdy_n;

    // Capture the data-phase context and the expected parity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q.vld     <= dphase;
            s1_q.exp_par <= ^{ad, cbe_n};
            s1_q.rx      <= dphase && rx_write;
            s1_q.posted  <= dphase && posted;
            s1_q.dw      <= dphase && rx_write && !posted && dw_stat_rdy;
            s1_q.pb      <= dphase && passback;
        end
    end

    // Compare PAR arriving now with the captured expectation.
    always_comb begin
        mismatch = par ^ s1_q.exp_par;
        det_err  = s1_q.vld && mismatch;
    end

    // Register the responses so they appear two clocks after the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_req   <= 1'b0;
            fwd_req    <= 1'b0;
            dw_release <= 1'b0;
            dw_hold    <= 1'b0;
        end else begin
            perr_req   <= (det_err && s1_q.rx && own_en) || (s1_q.pb && both_en);
            fwd_req    <= det_err && s1_q.rx && s1_q.posted;
            dw_release <= s1_q.dw && !mismatch;
            dw_hold    <= s1_q.dw && mismatch;
        end
    end

    // R9: a clock without a full handshake never yields a detected error next clock.
    p_no_check_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_n || trdy_n) |=> !det_err);

    // R7: release and hold exclude each other.
    p_hold_release_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dw_hold && dw_release));

    // R6: forwarding is only for posted writes, never alongside a delayed decision.
    p_fwd_only_posted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_req |-> !(dw_hold || dw_release));

endmodule

// File: rtl/pci_perr_driver.sv
// Shapes PERR# for one side: low while a request is present, high for one
// clock after the last low clock, then released. Assumes the request comes
// from a register.
module pci_perr_driver (
    input  logic clk,
    input  logic rst_n,
    input  logic perr_req,
    output logic perr_n,
    output logic perr_oe
);

    logic last_q;

    // Remember that PERR# was low so it is driven high for one more clock.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= perr_req;
    end

    // Drive the pin value and its enable.
    always_comb begin
        perr_n  = !perr_req;
        perr_oe = perr_req || last_q;
    end

    // R3: a low PERR# is always driven.
    p_perr_low_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> perr_oe);

    // R4: the clock after the last low one is driven high.
    p_perr_release_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_req) |-> (perr_oe && perr_n));

endmodule

// File: rtl/pci_par_status.sv
// Sticky detected-parity-error bits, one per side, cleared by writing ones.
// Assumes a new error and a clear in the same clock leave the bit set.
module pci_par_status #(
    parameter int NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_err,
    input  logic             clr_wr,
    input  logic [NBITS-1:0] clr_mask,
    output logic [NBITS-1:0] stat
);

    logic [NBITS-1:0] clr_eff;
    logic [NBITS-1:0] keep;

    // Bits selected for clearing this clock.
    always_comb begin
        clr_eff = clr_wr ? clr_mask : '0;
        keep    = stat & ~clr_eff;
    end

    // Hold, clear and set the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= keep | set_err;
    end

    // R2: bits not being cleared stay set.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|keep) |=> ((stat & $past(keep)) == $past(keep)));

    // R2: a clear with no competing error empties the selected bits.
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !(|set_err)) |=> ((stat & $past(clr_mask)) == '0));

endmodule

// File: rtl/pci_parity_responder.sv
// Top of the bridge parity responder. Runs one parity pipeline and one PERR#
// driver per side, routes forward-bad-parity to the opposite side and keeps
// the sticky status. Assumes enables are stable across a transfer.
module pci_parity_responder
    import pci_par_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_perr_en,
    input  logic              sec_perr_en,
    input  logic [DATA_W-1:0] p_ad,
    input  logic [BE_W-1:0]   p_cbe_n,
    input  logic              p_par,
    input  logic              p_irdy_n,
    input  logic              p_trdy_n,
    input  logic              p_rx_write,
    input  logic              p_posted,
    input  logic              p_dw_stat_rdy,
    input  logic              p_passback,
    input  logic [DATA_W-1:0] s_ad,
    input  logic [BE_W-1:0]   s_cbe_n,
    input  logic              s_par,
    input  logic              s_irdy_n,
    input  logic              s_trdy_n,
    input  logic              s_rx_write,
    input  logic              s_posted,
    input  logic              s_dw_stat_rdy,
    input  logic              s_passback,
    input  logic              stat_clr_wr,
    input  logic [NSIDE-1:0]  stat_clr_mask,
    output logic [NSIDE-1:0]  par_err_stat,
    output logic              p_perr_n,
    output logic              p_perr_oe,
    output logic              s_perr_n,
    output logic              s_perr_oe,
    output logic              p_fwd_bad_par,
    output logic              s_fwd_bad_par,
    output logic              p_dw_release,
    output logic              p_dw_hold,
    output logic              s_dw_release,
    output logic              s_dw_hold
);

    logic [DATA_W-1:0] ad_v   [NSIDE];
    logic [BE_W-1:0]   cbe_v  [NSIDE];
    logic [NSIDE-1:0]  par_v, irdy_v, trdy_v, rx_v, post_v, dwr_v, pb_v, own_en_v;
    logic [NSIDE-1:0]  det_v, req_v, fwd_v, rel_v, hold_v, perr_n_v, oe_v;
    logic              both_en;

    // Gather the per-side inputs into side-indexed vectors.
    always_comb begin
        ad_v[SIDE_PRI]  = p_ad;
        ad_v[SIDE_SEC]  = s_ad;
        cbe_v[SIDE_PRI] = p_cbe_n;
        cbe_v[SIDE_SEC] = s_cbe_n;
        par_v    = {s_par, p_par};
        irdy_v   = {s_irdy_n, p_irdy_n};
        trdy_v   = {s_trdy_n, p_trdy_n};
        rx_v     = {s_rx_write, p_rx_write};
        post_v   = {s_posted, p_posted};
        dwr_v    = {s_dw_stat_rdy, p_dw_stat_rdy};
        pb_v     = {s_passback, p_passback};
        own_en_v = {sec_perr_en, pri_perr_en};
        both_en  = pri_perr_en && sec_perr_en;
    end

    for (genvar gi = 0; gi < NSIDE; gi++) begin : g_side
        pci_par_side_pipe #(
            .DATA_W (DATA_W),
            .BE_W   (BE_W)
        ) i_pipe (
            .clk         (clk),
            .rst_n       (rst_n),
            .ad          (ad_v[gi]),
            .cbe_n       (cbe_v[gi]),
            .par         (par_v[gi]),
            .irdy_n      (irdy_v[gi]),
            .trdy_n      (trdy_v[gi]),
            .rx_write    (rx_v[gi]),
            .posted      (post_v[gi]),
            .dw_stat_rdy (dwr_v[gi]),
            .passback    (pb_v[gi]),
            .own_en      (own_en_v[gi]),
            .both_en     (both_en),
            .det_err     (det_v[gi]),
            .perr_req    (req_v[gi]),
            .fwd_req     (fwd_v[gi]),
            .dw_release  (rel_v[gi]),
            .dw_hold     (hold_v[gi])
        );

        pci_perr_driver i_perr (
            .clk      (clk),
            .rst_n    (rst_n),
            .perr_req (req_v[gi]),
            .perr_n   (perr_n_v[gi]),
            .perr_oe  (oe_v[gi])
        );
    end

    pci_par_status #(
        .NBITS (NSIDE)
    ) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_err  (det_v),
        .clr_wr   (stat_clr_wr),
        .clr_mask (stat_clr_mask),
        .stat     (par_err_stat)
    );

    // Spread the per-side results onto the ports; forwarding crosses sides.
    always_comb begin
        p_perr_n      = perr_n_v[SIDE_PRI];
        p_perr_oe     = oe_v[SIDE_PRI];
        s_perr_n      = perr_n_v[SIDE_SEC];
        s_perr_oe     = oe_v[SIDE_SEC];
        s_fwd_bad_par = fwd_v[SIDE_PRI];
        p_fwd_bad_par = fwd_v[SIDE_SEC];
        p_dw_release  = rel_v[SIDE_PRI];
        p_dw_hold     = hold_v[SIDE_PRI];
        s_dw_release  = rel_v[SIDE_SEC];
        s_dw_hold     = hold_v[SIDE_SEC];
    end

    // R5: PERR# from any cause needs at least one enable set when it is raised.
    p_perr_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(p_perr_oe) || $rose(s_perr_oe)) |-> $past(pri_perr_en || sec_perr_en));

endmodule

// File: tb/test_pci_parity_responder.sv
module test_pci_parity_responder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pri_perr_en, sec_perr_en;
    logic [31:0] p_ad, s_ad;
    logic [3:0]  p_cbe_n, s_cbe_n;
    logic        p_par, p_irdy_n, p_trdy_n, p_rx_write, p_posted, p_dw_stat_rdy, p_passback;
    logic        s_par, s_irdy_n, s_trdy_n, s_rx_write, s_posted, s_dw_stat_rdy, s_passback;
    logic        stat_clr_wr;
    logic [1:0]  stat_clr_mask;
    logic [1:0]  par_err_stat;
    logic        p_perr_n, p_perr_oe, s_perr_n, s_perr_oe;
    logic        p_fwd_bad_par, s_fwd_bad_par;
    logic        p_dw_release, p_dw_hold, s_dw_release, s_dw_hold;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_parity_responder i_pci_parity_responder (
        .clk(clk), .rst_n(rst_n), .pri_perr_en(pri_perr_en), .sec_perr_en(sec_perr_en),
        .p_ad(p_ad), .p_cbe_n(p_cbe_n), .p_par(p_par), .p_irdy_n(p_irdy_n), .p_trdy_n(p_trdy_n),
        .p_rx_write(p_rx_write), .p_posted(p_posted), .p_dw_stat_rdy(p_dw_stat_rdy),
        .p_passback(p_passback),
        .s_ad(s_ad), .s_cbe_n(s_cbe_n), .s_par(s_par), .s_irdy_n(s_irdy_n), .s_trdy_n(s_trdy_n),
        .s_rx_write(s_rx_write), .s_posted(s_posted), .s_dw_stat_rdy(s_dw_stat_rdy),
        .s_passback(s_passback),
        .stat_clr_wr(stat_clr_wr), .stat_clr_mask(stat_clr_mask), .par_err_stat(par_err_stat),
        .p_perr_n(p_perr_n), .p_perr_oe(p_perr_oe), .s_perr_n(s_perr_n), .s_perr_oe(s_perr_oe),
        .p_fwd_bad_par(p_fwd_bad_par), .s_fwd_bad_par(s_fwd_bad_par),
        .p_dw_release(p_dw_release), .p_dw_hold(p_dw_hold),
        .s_dw_release(s_dw_release), .s_dw_hold(s_dw_hold)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_idle();
        p_ad = '0; p_cbe_n = '0; p_par = 1'b0; p_irdy_n = 1'b1; p_trdy_n = 1'b1;
        p_rx_write = 1'b0; p_posted = 1'b0; p_dw_stat_rdy = 1'b0; p_passback = 1'b0;
        s_ad = '0; s_cbe_n = '0; s_par = 1'b0; s_irdy_n = 1'b1; s_trdy_n = 1'b1;
        s_rx_write = 1'b0; s_posted = 1'b0; s_dw_stat_rdy = 1'b0; s_passback = 1'b0;
        stat_clr_wr = 1'b0; stat_clr_mask = '0;
    endtask

    // Drive one data phase on a side; returns after the handshake clock.
    task automatic drive_phase(input int side, input logic [31:0] ad, input logic [3:0] cbe,
                               input logic irdy_n, input logic trdy_n, input logic rx,
                               input logic posted, input logic dwr, input logic pb);
        if (side == 0) begin
            p_ad = ad; p_cbe_n = cbe; p_irdy_n = irdy_n; p_trdy_n = trdy_n;
            p_rx_write = rx; p_posted = posted; p_dw_stat_rdy = dwr; p_passback = pb;
        end else begin
            s_ad = ad; s_cbe_n = cbe; s_irdy_n = irdy_n; s_trdy_n = trdy_n;
            s_rx_write = rx; s_posted = posted; s_dw_stat_rdy = dwr; s_passback = pb;
        end
    endtask

    // Even parity for PAR, optionally corrupted.
    function automatic logic par_of(input logic [31:0] ad, input logic [3:0] cbe, input logic bad);
        int ones = 0;
        for (int b = 0; b < 32; b++) ones += ad[b];
        for (int b = 0; b < 4; b++)  ones += cbe[b];
        return logic'(ones % 2) ^ bad;
    endfunction

    task automatic sweep_case(input int side, input logic bad, input logic [1:0] ptype,
                              input logic rx, input logic posted, input logic dwr,
                              input logic pb, input logic [1:0] en, input int seed);
        logic [31:0] ad;
        logic [3:0]  cbe;
        logic dp, err, own, both, e_perr, e_fwd, e_rel, e_hold;
        logic n_perr_n, n_oe, f_perr_oe, far_fwd, near_fwd, n_rel, n_hold, f_rel, f_hold;
        string tag_st, tag_perr;
        ad  = (32'(seed) * 32'h9E37_79B1) ^ (32'h1 << (seed % 32));
        cbe = 4'(seed * 7);
        @(negedge clk);
        pri_perr_en = en[0];
        sec_perr_en = en[1];
        drive_phase(side, ad, cbe, ptype[0], ptype[1], rx, posted, dwr, pb);
        @(negedge clk);
        drive_phase(side, ad, cbe, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        if (side == 0) p_par = par_of(ad, cbe, bad);
        else           s_par = par_of(ad, cbe, bad);
        @(negedge clk);
        dp     = (ptype == 2'b00);
        err    = dp && bad;
        own    = (side == 0) ? en[0] : en[1];
        both   = en[0] && en[1];
        e_perr = (err && rx && own) || (dp && pb && both);
        e_fwd  = err && rx && posted;
        e_rel  = dp && rx && !posted && dwr && !bad;
        e_hold = dp && rx && !posted && dwr && bad;
        n_perr_n  = (side == 0) ? p_perr_n  : s_perr_n;
        n_oe      = (side == 0) ? p_perr_oe : s_perr_oe;
        f_perr_oe = (side == 0) ? s_perr_oe : p_perr_oe;
        far_fwd   = (side == 0) ? s_fwd_bad_par : p_fwd_bad_par;
        near_fwd  = (side == 0) ? p_fwd_bad_par : s_fwd_bad_par;
        n_rel     = (side == 0) ? p_dw_release : s_dw_release;
        n_hold    = (side == 0) ? p_dw_hold    : s_dw_hold;
        f_rel     = (side == 0) ? s_dw_release : p_dw_release;
        f_hold    = (side == 0) ? s_dw_hold    : p_dw_hold;
        tag_st    = dp ? "R1" : "R9";
        tag_perr  = pb ? "R5" : "R3";
        check(tag_st,   "status after phase", 32'(par_err_stat), 32'(err) << side);
        check(tag_perr, "PERR# value", 32'(n_perr_n), 32'(!e_perr));
        check(tag_perr, "PERR# enable", 32'(n_oe), 32'(e_perr));
        check("R3", "other side PERR# enable", 32'(f_perr_oe), 32'h0);
        check("R6", "far forward bad parity", 32'(far_fwd), 32'(e_fwd));
        check("R6", "near forward bad parity", 32'(near_fwd), 32'h0);
        check("R7", "dw release", 32'(n_rel), 32'(e_rel));
        check("R7", "dw hold", 32'(n_hold), 32'(e_hold));
        check("R7", "other side dw pulses", 32'({f_rel, f_hold}), 32'h0);
        stat_clr_wr = 1'b1;
        stat_clr_mask = 2'b11;
        if (side == 0) p_par = 1'b0;
        else           s_par = 1'b0;
        @(negedge clk);
        stat_clr_wr = 1'b0;
        check("R2", "status after clear", 32'(par_err_stat), 32'h0);
        check("R4", "PERR# high after low",
              32'((side == 0) ? p_perr_n : s_perr_n), 32'h1);
        check("R4", "PERR# enable tail",
              32'((side == 0) ? p_perr_oe : s_perr_oe), 32'(e_perr));
        @(negedge clk);
        check("R4", "PERR# released",
              32'((side == 0) ? p_perr_oe : s_perr_oe), 32'h0);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed = 1;
        bus_idle();
        pri_perr_en = 1'b1;
        sec_perr_en = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset values while reset is held
        check("R8", "status in reset", 32'(par_err_stat), 32'h0);
        check("R8", "PERR# enables in reset", 32'({p_perr_oe, s_perr_oe}), 32'h0);
        check("R8", "PERR# values in reset", 32'({p_perr_n, s_perr_n}), 32'h3);
        check("R8", "pulses in reset",
              32'({p_fwd_bad_par, s_fwd_bad_par, p_dw_release, p_dw_hold,
                   s_dw_release, s_dw_hold}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "status after reset", 32'(par_err_stat), 32'h0);
        check("R8", "PERR# enables after reset", 32'({p_perr_oe, s_perr_oe}), 32'h0);

        // Near-exhaustive sweep of the decision inputs.
        for (int side = 0; side < 2; side++)
            for (int bad = 0; bad < 2; bad++)
                for (int pt = 0; pt < 4; pt++)
                    for (int fl = 0; fl < 16; fl++)
                        for (int en = 0; en < 4; en++) begin
                            sweep_case(side, logic'(bad), 2'(pt), fl[0], fl[1], fl[2],
                                       fl[3], 2'(en), seed);
                            seed++;
                        end

        // R4: back-to-back errors on primary keep PERR# low two clocks.
        @(negedge clk);
        pri_perr_en = 1'b1; sec_perr_en = 1'b0;
        drive_phase(0, 32'hA5A5_0001, 4'h3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        p_par = par_of(32'hA5A5_0001, 4'h3, 1'b1);
        drive_phase(0, 32'h0F0F_1234, 4'hC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        p_par = par_of(32'h0F0F_1234, 4'hC, 1'b1);
        drive_phase(0, 32'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4", "b2b first low", 32'({p_perr_oe, p_perr_n}), 32'h2);
        @(negedge clk);
        p_par = 1'b0;
        check("R4", "b2b second low", 32'({p_perr_oe, p_perr_n}), 32'h2);
        @(negedge clk);
        check("R4", "b2b high tail", 32'({p_perr_oe, p_perr_n}), 32'h3);
        @(negedge clk);
        check("R4", "b2b released", 32'(p_perr_oe), 32'h0);
        check("R2", "status sticky over idle", 32'(par_err_stat), 32'h1);
        repeat (3) @(negedge clk);
        check("R2", "status still set", 32'(par_err_stat), 32'h1);
        stat_clr_wr = 1'b1; stat_clr_mask = 2'b10;
        @(negedge clk);
        stat_clr_wr = 1'b0;
        check("R2", "clear of other bit leaves primary", 32'(par_err_stat), 32'h1);
        stat_clr_wr = 1'b1; stat_clr_mask = 2'b01;
        @(negedge clk);
        stat_clr_wr = 1'b0;
        check("R2", "primary cleared", 32'(par_err_stat), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule